// File: doc/BRIEF.md
# Papertape Load Record Decoder

This block turns a stream of ASCII characters into memory writes. It is meant for the loader path of a small monitor: a receiver hands it one character at a time with a valid strobe. The block finds each load record, checks it, and writes every data byte to memory.

A record starts with a colon. The colon is followed by a load address, a byte count and a checksum over those header bytes. Then come the data bytes, a checksum over the data, and a carriage return. A record with a count of zero closes the load. Its address field is reported as the program entry address on a one-cycle done pulse. A checksum mismatch or a malformed character raises a one-cycle error pulse, and the rest of that record is dropped.

Top module: `tape_loader`

## Requirements
- R1: While the block is waiting for a record, every character except a colon (0x3A) produces no output.
- R2: A record has these fields in this order: a colon, four hex characters of address (most significant first), two hex characters of byte count N (0 to 255), two hex characters of header checksum, 2×N hex characters of data, two hex characters of data checksum, and a carriage return (0x0D). The first data byte goes to the record address. A new record may begin on the cycle right after the carriage return.
- R3: Each data byte is made from two hex characters, the first being the high nibble. The byte appears on `wrData` with `wrEn` high for exactly one cycle, in the cycle after its second character is accepted. The bytes of a record go to consecutive addresses.
- R4: The header checksum starts at 0. For each of the address high byte, the address low byte and the count, the checksum is rotated left by one bit and then XORed with that byte. If the received header checksum differs, `errPulse` is high in the cycle after its second character, no data byte of that record is written, and the block ignores characters until the next colon.
- R5: The data checksum uses the same rule over the data bytes in order. If it differs, `errPulse` is high in the cycle after its second character. Bytes already written stay written.
- R6: A record with count 0 ends the load. If its header checksum matches, `donePulse` is high for one cycle in the cycle after the second header checksum character, and `entryAddr` then equals the record's address field. Characters after that are ignored until the next colon. If the header checksum does not match, `errPulse` is raised instead and `donePulse` stays low.
- R7: Hex digits 0-9, A-F and a-f are accepted, and upper and lower case give the same value.
- R8: Inside any hex field, a character that is not a hex digit (a colon included) raises `errPulse` in the next cycle and abandons the record.
- R9: If the character after a matching data checksum is not a carriage return, `errPulse` is raised.
- R10: A character presented while `chValid` is low has no effect.
- R11: Write addresses wrap from 0xFFFF to 0x0000 within a record.
- R12: While and right after reset, `wrEn`, `errPulse` and `donePulse` are low.
- R13: In any cycle, at most one of `wrEn`, `errPulse` and `donePulse` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chValid | input | 1 | `chData` holds a character this cycle |
| chData | input | 8 | ASCII character |
| wrEn | output | 1 | Write strobe for one data byte |
| wrAddr | output | 16 | Write address |
| wrData | output | 8 | Write data |
| errPulse | output | 1 | Checksum mismatch or malformed record |
| donePulse | output | 1 | End-of-load record accepted |
| entryAddr | output | 16 | Entry address, valid while `donePulse` is high |

## Verification
Two events can overlap in time. The registered write of a record's last data byte is still on the outputs while the first data checksum character is being accepted. Likewise, the carriage return that ends one record is followed on the very next cycle by the colon of the next. The bench provokes both by holding `chValid` high through several records placed back to back, including records of length 1 and 255. It judges them by matching every output pulse, in order, against a queue of expected writes, errors and done events. A missed, extra or reordered event counts as a failure.

// File: rtl/tape_pkg.sv
package tape_pkg;

  localparam logic [7:0] CH_MARK = 8'h3A;  // record start
  localparam logic [7:0] CH_END  = 8'h0D;  // record end
  localparam int         LEN_W   = 8;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_ADDR,
    ST_LEN,
    ST_HSUM,
    ST_DATA,
    ST_DSUM,
    ST_EOL
  } parseState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startRec;
    logic takeHigh;
    logic addrByte;
    logic lenByte;
    logic dataByte;
  } dpStrobe_t;

  // running check: rotate left one bit, then fold the new byte in
  function automatic logic [7:0] foldSum(input logic [7:0] acc, input logic [7:0] b);
    return {acc[6:0], acc[7]} ^ b;
  endfunction

endpackage

// File: rtl/tape_hexdec.sv
module tape_hexdec (
  input  logic [7:0] ch,
  output logic       isHex,
  output logic [3:0] nib
);

  always_comb begin
    isHex = 1'b1;
    nib   = 4'h0;
    if (ch >= 8'h30 && ch <= 8'h39) begin
      nib = ch[3:0];
    end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
      nib = ch[3:0] + 4'd9;
    end else begin
      isHex = 1'b0;
    end
  end

endmodule

// File: rtl/tape_datapath.sv
module tape_datapath
  import tape_pkg::*;
#(
  parameter int ADDR_NIBS = 4,
  localparam int ADDR_W = 4 * ADDR_NIBS
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [3:0]        nibIn,
  output logic              hdrOk,
  output logic              datOk,
  output logic              lenZero,
  output logic              lastData,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic [ADDR_W-1:0] recAddr
);

  logic [3:0]        hiNib;
  logic [ADDR_W-1:0] addrReg;
  logic [LEN_W-1:0]  lenReg;
  logic [LEN_W-1:0]  cntReg;
  logic [7:0]        hdrSum;
  logic [7:0]        datSum;
  logic [7:0]        byteNow;

  assign byteNow = {hiNib, nibIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiNib   <= '0;
      addrReg <= '0;
      lenReg  <= '0;
      cntReg  <= '0;
      hdrSum  <= '0;
      datSum  <= '0;
      wrEn    <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrEn <= 1'b0;
      if (strobe.takeHigh) hiNib <= nibIn;
      if (strobe.startRec) begin
        hdrSum <= '0;
        datSum <= '0;
      end
      if (strobe.addrByte) begin
        addrReg <= (addrReg << 8) | ADDR_W'(byteNow);
        hdrSum  <= foldSum(hdrSum, byteNow);
      end
      if (strobe.lenByte) begin
        lenReg <= byteNow;
        cntReg <= byteNow;
        hdrSum <= foldSum(hdrSum, byteNow);
      end
      if (strobe.dataByte) begin
        wrEn    <= 1'b1;
        wrAddr  <= addrReg;
        wrData  <= byteNow;
        addrReg <= addrReg + 1'b1;
        cntReg  <= cntReg - 1'b1;
        datSum  <= foldSum(datSum, byteNow);
      end
    end
  end

  assign hdrOk    = (byteNow == hdrSum);
  assign datOk    = (byteNow == datSum);
  assign lenZero  = (lenReg == '0);
  assign lastData = (cntReg == LEN_W'(1));
  assign recAddr  = addrReg;

  // control never asks for a data byte once the count is spent
  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataByte |-> (cntReg != '0)); // R2

endmodule

// File: rtl/tape_ctrl.sv
module tape_ctrl
  import tape_pkg::*;
#(
  parameter int ADDR_NIBS = 4,
  localparam int POS_W = (ADDR_NIBS > 2) ? $clog2(ADDR_NIBS) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chValid,
  input  logic [7:0] chData,
  input  logic       isHex,
  input  logic       hdrOk,
  input  logic       datOk,
  input  logic       lenZero,
  input  logic       lastData,
  output dpStrobe_t  strobe,
  output logic       errPulse,
  output logic       donePulse
);

  parseState_t      state, nextState;
  logic [POS_W-1:0] pos, nextPos;
  logic             errNext, doneNext;

  always_comb begin
    nextState = state;
    nextPos   = pos;
    strobe    = '0;
    errNext   = 1'b0;
    doneNext  = 1'b0;
    if (chValid) begin
      case (state)
        ST_HUNT: begin
          if (chData == CH_MARK) begin
            strobe.startRec = 1'b1;
            nextState       = ST_ADDR;
            nextPos         = '0;
          end
        end
        ST_EOL: begin
          nextState = ST_HUNT;
          if (chData != CH_END) errNext = 1'b1;
        end
        default: begin
          if (!isHex) begin
            errNext   = 1'b1;
            nextState = ST_HUNT;
          end else if (!pos[0]) begin
            strobe.takeHigh = 1'b1;
            nextPos         = pos + 1'b1;
          end else begin
            nextPos = '0;
            case (state)
              ST_ADDR: begin
                strobe.addrByte = 1'b1;
                if (pos == POS_W'(ADDR_NIBS - 1)) nextState = ST_LEN;
                else nextPos = pos + 1'b1;
              end
              ST_LEN: begin
                strobe.lenByte = 1'b1;
                nextState      = ST_HSUM;
              end
              ST_HSUM: begin
                if (!hdrOk) begin
                  errNext   = 1'b1;
                  nextState = ST_HUNT;
                end else if (lenZero) begin
                  doneNext  = 1'b1;
                  nextState = ST_HUNT;
                end else begin
                  nextState = ST_DATA;
                end
              end
              ST_DATA: begin
                strobe.dataByte = 1'b1;
                if (lastData) nextState = ST_DSUM;
              end
              ST_DSUM: begin
                if (!datOk) begin
                  errNext   = 1'b1;
                  nextState = ST_HUNT;
                end else begin
                  nextState = ST_EOL;
                end
              end
              default: nextState = ST_HUNT;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_HUNT;
      pos       <= '0;
      errPulse  <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      state     <= nextState;
      pos       <= nextPos;
      errPulse  <= errNext;
      donePulse <= doneNext;
    end
  end

  AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HUNT && chValid && chData != CH_MARK) |=> !(errPulse || donePulse)); // R1
  AST_DONE_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> $past(chValid)); // R6
  AST_ERR_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(chValid)); // R8
  AST_EOL_CHECKED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EOL && chValid && chData != CH_END) |=> errPulse); // R9

endmodule

// File: rtl/tape_loader.sv
module tape_loader
  import tape_pkg::*;
#(
  parameter int ADDR_NIBS = 4,
  localparam int ADDR_W = 4 * ADDR_NIBS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chValid,
  input  logic [7:0]        chData,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              errPulse,
  output logic              donePulse,
  output logic [ADDR_W-1:0] entryAddr
);

  dpStrobe_t  strobe;
  logic       isHex;
  logic [3:0] nib;
  logic       hdrOk, datOk, lenZero, lastData;

  tape_hexdec hex_i (
    .ch    (chData),
    .isHex (isHex),
    .nib   (nib)
  );

  tape_ctrl #(.ADDR_NIBS(ADDR_NIBS)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .chValid   (chValid),
    .chData    (chData),
    .isHex     (isHex),
    .hdrOk     (hdrOk),
    .datOk     (datOk),
    .lenZero   (lenZero),
    .lastData  (lastData),
    .strobe    (strobe),
    .errPulse  (errPulse),
    .donePulse (donePulse)
  );

  tape_datapath #(.ADDR_NIBS(ADDR_NIBS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .nibIn    (nib),
    .hdrOk    (hdrOk),
    .datOk    (datOk),
    .lenZero  (lenZero),
    .lastData (lastData),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .recAddr  (entryAddr)
  );

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrEn, errPulse, donePulse})); // R13
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(chValid) |-> !(wrEn || errPulse || donePulse)); // R10
  AST_WRITE_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(chValid)); // R3

endmodule

// File: tb/tape_loader_tb.sv
module tape_loader_tb_top;

  localparam int         CLK_PERIOD = 10;
  localparam logic [7:0] COLON = 8'h3A;
  localparam logic [7:0] CR    = 8'h0D;
  localparam logic [1:0] EV_WR = 2'd0, EV_ERR = 2'd1, EV_DONE = 2'd2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chValid = 1'b0;
  logic [7:0]  chData = 8'h00;
  logic        wrEn, errPulse, donePulse;
  logic [15:0] wrAddr, entryAddr;
  logic [7:0]  wrData;

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  data;
  } evt_t;

  evt_t  expQ[$];
  string tagQ[$];
  int    checks = 0;
  int    errors = 0;
  int    unexp = 0;
  bit    finished = 1'b0;
  string curTag = "R12";
  logic [7:0] payload [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  tape_loader dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .chValid   (chValid),
    .chData    (chData),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .errPulse  (errPulse),
    .donePulse (donePulse),
    .entryAddr (entryAddr)
  );

  function automatic logic [7:0] fold(input logic [7:0] s, input logic [7:0] b);
    return {s[6:0], s[7]} ^ b;
  endfunction

  function automatic logic [7:0] hexChar(input logic [3:0] n, input bit lower);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    return (lower ? 8'h61 : 8'h41) + {4'h0, n - 4'd10};
  endfunction

  task automatic expectEv(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d,
                          input string tag);
    evt_t e;
    e.kind = k; e.addr = a; e.data = d;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic putChar(input logic [7:0] c, input int gap);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk); chValid = 1'b0; chData = COLON;
      @(posedge clk);
    end
    @(negedge clk); chValid = 1'b1; chData = c;
    @(posedge clk);
  endtask

  task automatic putHex(input logic [7:0] b, input bit lower, input int gap);
    putChar(hexChar(b[7:4], lower), gap);
    putChar(hexChar(b[3:0], lower), gap);
  endtask

  task automatic sendRecord(input logic [15:0] addr, input int len, input logic [7:0] hdrFlip,
                            input logic [7:0] datFlip, input bit lower, input int gap,
                            input logic [7:0] eolCh, input string tag);
    logic [7:0]  hs, ds;
    logic [15:0] a;
    bit ok;
    hs = fold(fold(fold(8'h00, addr[15:8]), addr[7:0]), len[7:0]);
    putChar(COLON, gap);
    putHex(addr[15:8], lower, gap);
    putHex(addr[7:0], lower, gap);
    putHex(len[7:0], lower, gap);
    putHex(hs ^ hdrFlip, lower, gap);
    ok = (hdrFlip == 8'h00);
    if (!ok) expectEv(EV_ERR, 16'h0, 8'h0, tag);
    else if (len == 0) begin
      expectEv(EV_DONE, addr, 8'h0, tag);
      return;
    end
    a = addr; ds = 8'h00;
    for (int i = 0; i < len; i++) begin
      putHex(payload[i], lower, gap);
      if (ok) expectEv(EV_WR, a, payload[i], tag);
      a = a + 16'd1;
      ds = fold(ds, payload[i]);
    end
    putHex(ds ^ datFlip, lower, gap);
    if (ok && datFlip != 8'h00) begin
      expectEv(EV_ERR, 16'h0, 8'h0, tag);
      ok = 1'b0;
    end
    putChar(eolCh, gap);
    if (ok && eolCh != CR) expectEv(EV_ERR, 16'h0, 8'h0, tag);
  endtask

  task automatic phaseEnd(input string tag);
    @(negedge clk); chValid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (expQ.size() != 0 || unexp != 0) begin
      errors++;
      $display("FAIL %s: pending=%0d unexpected=%0d, expected pending=0 unexpected=0",
               tag, expQ.size(), unexp);
    end
    expQ.delete(); tagQ.delete(); unexp = 0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: every output pulse must match the head of the expectation queue
  always @(negedge clk) begin : monitor
    evt_t  got, want;
    string t;
    if (rstN && (wrEn || errPulse || donePulse)) begin
      got.kind = wrEn ? EV_WR : (errPulse ? EV_ERR : EV_DONE);
      got.addr = wrEn ? wrAddr : (donePulse ? entryAddr : 16'h0);
      got.data = wrEn ? wrData : 8'h0;
      checks++;
      if (expQ.size() == 0) begin
        errors++; unexp++;
        $display("FAIL %s: unexpected kind=%0d addr=%h data=%h, expected no event",
                 curTag, got.kind, got.addr, got.data);
      end else begin
        want = expQ.pop_front();
        t = tagQ.pop_front();
        if (got != want) begin
          errors++;
          $display("FAIL %s: kind=%0d addr=%h data=%h, expected kind=%0d addr=%h data=%h",
                   t, got.kind, got.addr, got.data, want.kind, want.addr, want.data);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finishRun();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;  // R12 reset state
    if (wrEn || errPulse || donePulse) begin
      errors++;
      $display("FAIL R12: wrEn=%b errPulse=%b donePulse=%b, expected 0 0 0",
               wrEn, errPulse, donePulse);
    end
    rstN = 1'b1;

    // R1: noise before the colon, then a clean upper-case record (R2, R3, R5)
    curTag = "R1";
    putChar(8'h78, 0); putChar(8'h31, 0); putChar(CR, 0); putChar(8'h47, 0);
    payload[0] = 8'hAA; payload[1] = 8'h55; payload[2] = 8'h0F;
    sendRecord(16'h1234, 3, 8'h00, 8'h00, 1'b0, 0, CR, "R3");
    phaseEnd("R1");

    // R7: lower-case digits
    curTag = "R7";
    payload[0] = 8'hDE; payload[1] = 8'hAD;
    sendRecord(16'h0ABC, 2, 8'h00, 8'h00, 1'b1, 0, CR, "R7");
    phaseEnd("R7");

    // R10: idle cycles with a colon on chData but chValid low
    curTag = "R10";
    payload[0] = 8'h7E; payload[1] = 8'h81;
    sendRecord(16'h2000, 2, 8'h00, 8'h00, 1'b0, 2, CR, "R10");
    phaseEnd("R10");

    // R4: bad header checksum, no writes, rest of record ignored
    curTag = "R4";
    payload[0] = 8'h01; payload[1] = 8'h02;
    sendRecord(16'h3000, 2, 8'h01, 8'h00, 1'b0, 0, CR, "R4");
    phaseEnd("R4");

    // R5: bad data checksum after writes
    curTag = "R5";
    payload[0] = 8'h11; payload[1] = 8'h22; payload[2] = 8'h33;
    sendRecord(16'h3100, 3, 8'h00, 8'h80, 1'b0, 0, CR, "R5");
    phaseEnd("R5");

    // R8: non-hex character inside data, and colon inside address
    curTag = "R8";
    putChar(COLON, 0);
    putHex(8'h40, 1'b0, 0); putHex(8'h00, 1'b0, 0); putHex(8'h03, 1'b0, 0);
    putHex(fold(fold(fold(8'h00, 8'h40), 8'h00), 8'h03), 1'b0, 0);
    putHex(8'h99, 1'b0, 0);
    expectEv(EV_WR, 16'h4000, 8'h99, "R8");
    putChar(8'h47, 0);
    expectEv(EV_ERR, 16'h0, 8'h0, "R8");
    putHex(8'h22, 1'b0, 0); putChar(CR, 0);
    putChar(COLON, 0); putChar(8'h35, 0); putChar(COLON, 0);
    expectEv(EV_ERR, 16'h0, 8'h0, "R8");
    putHex(8'h12, 1'b0, 0);
    phaseEnd("R8");

    // R9: wrong end-of-record character
    curTag = "R9";
    payload[0] = 8'h5A;
    sendRecord(16'h4400, 1, 8'h00, 8'h00, 1'b0, 0, 8'h58, "R9");
    phaseEnd("R9");

    // R11: address wraps
    curTag = "R11";
    payload[0] = 8'hC3; payload[1] = 8'h3C; payload[2] = 8'h96;
    sendRecord(16'hFFFE, 3, 8'h00, 8'h00, 1'b0, 0, CR, "R11");
    phaseEnd("R11");

    // R2/R13: back-to-back records, longest length, then a length-1 record
    curTag = "R13";
    for (int i = 0; i < 256; i++) payload[i] = 8'(i) ^ 8'h5A;
    sendRecord(16'h5000, 255, 8'h00, 8'h00, 1'b0, 0, CR, "R2");
    payload[0] = 8'hE7;
    sendRecord(16'h6000, 1, 8'h00, 8'h00, 1'b1, 0, CR, "R13");
    phaseEnd("R2");

    // R6: end-of-load record, trailing characters ignored, then a bad one
    curTag = "R6";
    sendRecord(16'h0440, 0, 8'h00, 8'h00, 1'b0, 0, CR, "R6");
    putHex(8'h00, 1'b0, 0); putChar(CR, 0);
    phaseEnd("R6");
    sendRecord(16'h0440, 0, 8'h04, 8'h00, 1'b0, 0, CR, "R6");
    phaseEnd("R6");

    finishRun();
  end

endmodule